// File: doc/BRIEF.md
# Line-Pointer Pixel Scanner

This block produces an 8-bit-per-pixel raster for a 640-pixel-wide display line from an external synchronous video RAM. Each RAM word holds two adjacent pixels. The block runs from the pixel clock and fetches one word every two pixel clocks. A fetch slot counter (the column) steps once per fetch. The word that comes back is latched into a pixel pair. In the following slot, the pair is shown low byte first and high byte second.

The RAM row is not derived from a frame counter. A host-written line register supplies it, so the host can aim every display line at any stored line. This makes vertical scrolling and screen clearing cheap: one blank line can be shared by every row on screen. When the column reaches a programmable compare value, the block raises an interrupt. The host then uses horizontal blanking in several ways:
- It restarts the column counter.
- It drives horizontal sync.
- It opens an access window. The window freezes the scan and gives the RAM address and write port to the host.

Top module: `vls_scanner`

## Requirements
- R1: After synchronous reset, `irq`, `hsync` and `ram_we` are low, `pix_out` is zero, and `ram_addr` is zero.
- R2: Outside the access window, the column steps by one every second clock, wraps from `SLOTS-1` to 0, and `ram_addr` equals `{line register, column}`.
- R3: The word fetched for column c is shown in the slot after c. Its bits [7:0] appear in the first clock of that slot and its bits [15:8] in the second.
- R4: Words fetched for columns at or above `VISIBLE` produce a zero pixel output.
- R5: `irq` goes high one clock after the first clock in which the column equals `irq_cmp`, and stays high until cleared.
- R6: The control word has fixed bit positions: bit 0 clears `irq`, bit 1 holds the access enable, bit 2 holds the sync level, and bit 3 restarts the column. A restart puts the column at 0, first half-slot, on the next clock.
- R7: While access is enabled, the column, the half-slot phase and `pix_out` hold their values. On release, counting resumes from the held state.
- R8: While access is enabled, `ram_addr` is `{line, host column}`. A line or host column written in a cycle is used in that same cycle, and `ram_we` follows `host_wen`. Without access, `ram_we` stays low.
- R9: `hsync` takes the sync bit of each control write on the next clock.
- R10: A line register write changes the row of the scan address from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_in | input | 4 | Control word (bit0 irq clear, bit1 access, bit2 sync, bit3 column restart) |
| irq_cmp | input | COL_W | Column value that raises the interrupt |
| line_we | input | 1 | Line register write strobe |
| line_in | input | LINE_W | Line register value (RAM row) |
| hcol_we | input | 1 | Host column register write strobe |
| hcol_in | input | COL_W | Host column for access-window writes |
| host_wen | input | 1 | Host write request |
| host_wdata | input | 2*PIX_W | Host write data (two pixels) |
| ram_addr | output | LINE_W+COL_W | Video RAM address |
| ram_wdata | output | 2*PIX_W | Video RAM write data |
| ram_we | output | 1 | Video RAM write enable |
| ram_rdata | input | 2*PIX_W | Video RAM read data, one clock after address |
| pix_out | output | PIX_W | Pixel colour |
| hsync | output | 1 | Horizontal sync level |
| irq | output | 1 | End-of-line interrupt request |

## Verification
All timing is counted in clocks from the edge that applies a control write. The scan address for cycle n shows column n/2. The two bytes of column c appear in cycles 2c+2 and 2c+3 because of the RAM read register and the pair register. The interrupt is due one clock after the column first reaches the compare value. Control, sync and line writes act on the next clock, while access-window addresses and write enables act in the same cycle. The bench drives on the falling edge and samples just after it, using a cycle index that it keeps itself, and compares against bytes computed from the pattern it wrote.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int CTRL_W       = 4;
  localparam int CTRL_IRQ_CLR = 0;
  localparam int CTRL_ACCESS  = 1;
  localparam int CTRL_SYNC    = 2;
  localparam int CTRL_CNT_RST = 3;
endpackage

// File: rtl/vls_column_counter.sv
module vls_column_counter #(
  parameter int COL_W = 9,
  parameter int SLOTS = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             clear,
  output logic [COL_W-1:0] col,
  output logic             phase,
  output logic             fetch_done
);
  localparam logic [COL_W-1:0] LAST = COL_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      col   <= '0;
      phase <= 1'b0;
    end else if (!freeze) begin
      phase <= ~phase;
      if (phase) col <= (col == LAST) ? '0 : col + COL_W'(1);
    end
  end

  // end of a slot: the word addressed in this slot is on the RAM output
  assign fetch_done = phase & ~freeze & ~clear;
endmodule

// File: rtl/vls_pixel_pair.sv
module vls_pixel_pair #(
  parameter int PIX_W   = 8,
  parameter int COL_W   = 9,
  parameter int VISIBLE = 320
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               phase,
  input  logic [COL_W-1:0]   col,
  input  logic [2*PIX_W-1:0] rdata,
  output logic [PIX_W-1:0]   pix_out
);
  logic [PIX_W-1:0] first_q, second_q;
  logic             vis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      second_q <= '0;
      vis_q    <= 1'b0;
    end else if (load) begin
      first_q  <= rdata[PIX_W-1:0];
      second_q <= rdata[2*PIX_W-1:PIX_W];
      vis_q    <= (col < COL_W'(VISIBLE));
    end
  end

  assign pix_out = !vis_q ? '0 : (phase ? second_q : first_q);
endmodule

// File: rtl/vls_irq_gen.sv
module vls_irq_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             phase,
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] cmp,
  input  logic             clr,
  output logic             irq
);
  logic hit;
  assign hit = !freeze && !phase && (col == cmp);

  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (hit) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/vls_scanner.sv
module vls_scanner
  import vls_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COL_W   = 9,
  parameter int LINE_W  = 9,
  parameter int SLOTS   = 400,
  parameter int VISIBLE = 320
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_we,
  input  logic [CTRL_W-1:0]       ctrl_in,
  input  logic [COL_W-1:0]        irq_cmp,
  input  logic                    line_we,
  input  logic [LINE_W-1:0]       line_in,
  input  logic                    hcol_we,
  input  logic [COL_W-1:0]        hcol_in,
  input  logic                    host_wen,
  input  logic [2*PIX_W-1:0]      host_wdata,
  output logic [LINE_W+COL_W-1:0] ram_addr,
  output logic [2*PIX_W-1:0]      ram_wdata,
  output logic                    ram_we,
  input  logic [2*PIX_W-1:0]      ram_rdata,
  output logic [PIX_W-1:0]        pix_out,
  output logic                    hsync,
  output logic                    irq
);
  logic              access_q;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  hcol_q;
  logic [COL_W-1:0]  col;
  logic              phase, fetch_done;
  logic              cnt_clr, irq_clr;

  assign cnt_clr = ctrl_we & ctrl_in[CTRL_CNT_RST];
  assign irq_clr = ctrl_we & ctrl_in[CTRL_IRQ_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      access_q <= 1'b0;
      hsync    <= 1'b0;
      line_q   <= '0;
      hcol_q   <= '0;
    end else begin
      if (ctrl_we) begin
        access_q <= ctrl_in[CTRL_ACCESS];
        hsync    <= ctrl_in[CTRL_SYNC];
      end
      if (line_we) line_q <= line_in;
      if (hcol_we) hcol_q <= hcol_in;
    end
  end

  vls_column_counter #(.COL_W(COL_W), .SLOTS(SLOTS)) u_cnt (
    .clk(clk), .rst(rst), .freeze(access_q), .clear(cnt_clr),
    .col(col), .phase(phase), .fetch_done(fetch_done)
  );

  vls_pixel_pair #(.PIX_W(PIX_W), .COL_W(COL_W), .VISIBLE(VISIBLE)) u_pair (
    .clk(clk), .rst(rst), .load(fetch_done), .phase(phase), .col(col),
    .rdata(ram_rdata), .pix_out(pix_out)
  );

  vls_irq_gen #(.COL_W(COL_W)) u_irq (
    .clk(clk), .rst(rst), .freeze(access_q), .phase(phase), .col(col),
    .cmp(irq_cmp), .clr(irq_clr), .irq(irq)
  );

  // host registers act as transparent latches inside the access window
  logic [LINE_W-1:0] line_eff;
  logic [COL_W-1:0]  hcol_eff;
  assign line_eff = line_we ? line_in : line_q;
  assign hcol_eff = hcol_we ? hcol_in : hcol_q;

  assign ram_addr  = access_q ? {line_eff, hcol_eff} : {line_q, col};
  assign ram_wdata = host_wdata;
  assign ram_we    = access_q & host_wen;
endmodule

// File: rtl/vls_scanner_chk.sv
module vls_scanner_chk #(
  parameter int COL_W = 9,
  parameter int SLOTS = 400,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             access_q,
  input logic             cnt_clr,
  input logic             irq_clr,
  input logic [COL_W-1:0] col,
  input logic             phase,
  input logic             irq,
  input logic [PIX_W-1:0] pix_out
);
  localparam logic [COL_W-1:0] LAST = COL_W'(SLOTS - 1);

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (rst) col <= LAST);

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!access_q && !cnt_clr && phase && col != LAST) |=> (col == $past(col) + COL_W'(1)));

  // R6
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (col == '0 && !phase));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (access_q && !cnt_clr) |=> ($stable(col) && $stable(phase)));

  // R7
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (access_q && !cnt_clr) |=> $stable(pix_out));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

bind vls_scanner vls_scanner_chk #(.COL_W(COL_W), .SLOTS(SLOTS), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .access_q(access_q), .cnt_clr(cnt_clr), .irq_clr(irq_clr),
  .col(col), .phase(phase), .irq(irq), .pix_out(pix_out)
);

// File: tb/vls_scanner_test.sv
module vls_scanner_test;
  localparam int PIX_W = 8, COL_W = 9, LINE_W = 3, SLOTS = 40, VISIBLE = 32;
  localparam int AW = LINE_W + COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_we = 1'b0;
  logic [3:0] ctrl_in = '0;
  logic [COL_W-1:0] irq_cmp = COL_W'(10);
  logic line_we = 1'b0, hcol_we = 1'b0, host_wen = 1'b0;
  logic [LINE_W-1:0] line_in = '0;
  logic [COL_W-1:0] hcol_in = '0;
  logic [15:0] host_wdata = '0;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic ram_we, hsync, irq;
  logic [7:0] pix_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mem [0:(1<<AW)-1];

  always #2 clk = ~clk;

  vls_scanner #(.PIX_W(PIX_W), .COL_W(COL_W), .LINE_W(LINE_W), .SLOTS(SLOTS), .VISIBLE(VISIBLE)) uut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_in(ctrl_in), .irq_cmp(irq_cmp),
    .line_we(line_we), .line_in(line_in), .hcol_we(hcol_we), .hcol_in(hcol_in),
    .host_wen(host_wen), .host_wdata(host_wdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .pix_out(pix_out), .hsync(hsync), .irq(irq)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [15:0] pat(int ln, int c);
    logic [7:0] lo, hi;
    lo = 8'h80 | 8'((c * 5 + ln) & 8'h7F);
    hi = 8'h40 | 8'((c * 3 + ln * 7) & 8'h3F);
    return {hi, lo};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_in = v;
    @(negedge clk); ctrl_we = 1'b0; #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(irq == 0 && hsync == 0 && ram_we == 0, "R1 flags", {irq, hsync, ram_we}, 0);
    chk(pix_out == 0, "R1 pix", pix_out, 0);
    chk(ram_addr == 0, "R1 addr", ram_addr, 0);

    // R8: no write without access
    @(negedge clk); host_wen = 1'b1; #1;
    chk(ram_we == 0, "R8 no access write", ram_we, 0);
    host_wen = 1'b0;

    // open access window and fill lines 2 and 5
    write_ctrl(4'b0010);
    for (int ln = 2; ln <= 5; ln += 3) begin
      for (int c = 0; c < SLOTS; c++) begin
        @(negedge clk);
        line_we = 1'b1; line_in = LINE_W'(ln);
        hcol_we = 1'b1; hcol_in = COL_W'(c);
        host_wen = 1'b1; host_wdata = pat(ln, c); #1;
        if (c == 0 || c == SLOTS - 1) begin
          chk(ram_addr == {LINE_W'(ln), COL_W'(c)} && ram_we == 1, "R8 access addr",
              ram_addr, {LINE_W'(ln), COL_W'(c)});
        end
      end
    end
    @(negedge clk); line_we = 1'b0; hcol_we = 1'b0; host_wen = 1'b0;
    line_in = LINE_W'(2); line_we = 1'b1;
    @(negedge clk); line_we = 1'b0;

    // restart column, clear irq, close access
    write_ctrl(4'b1001);
    for (int n = 0; n < 2 * SLOTS + 8; n++) begin
      int col_e, c, pe;
      col_e = (n / 2) % SLOTS;
      chk(ram_addr == {LINE_W'(2), COL_W'(col_e)}, "R2 scan addr", ram_addr, {LINE_W'(2), COL_W'(col_e)});
      if (n >= 2) begin
        c = (n / 2 + SLOTS - 1) % SLOTS;
        if (c >= VISIBLE) begin
          pe = 0;
          chk(pix_out == 8'(pe), "R4 blank", pix_out, pe);
        end else begin
          pe = (n % 2 == 0) ? int'(pat(2, c) & 16'hFF) : int'(pat(2, c) >> 8);
          chk(pix_out == 8'(pe), "R3 pixel", pix_out, pe);
        end
      end
      chk(irq == (n >= 21), "R5 irq", irq, (n >= 21));
      @(negedge clk); #1;
    end

    // R5 clear (column is not at compare value here)
    write_ctrl(4'b0001);
    chk(irq == 0, "R5 clear", irq, 0);

    // R10 line change mid scan
    @(negedge clk); line_we = 1'b1; line_in = LINE_W'(5);
    @(negedge clk); line_we = 1'b0; #1;
    chk(ram_addr[AW-1:COL_W] == 5, "R10 line", ram_addr[AW-1:COL_W], 5);

    // R6 restart then R7 freeze at cycle 6
    write_ctrl(4'b1000);
    chk(ram_addr[COL_W-1:0] == 0, "R6 restart", ram_addr[COL_W-1:0], 0);
    repeat (6) @(negedge clk);
    ctrl_we = 1'b1; ctrl_in = 4'b0010;
    @(negedge clk); ctrl_we = 1'b0; #1;
    begin
      logic [7:0] held;
      held = pix_out;
      chk(held == pat(5, 2)[15:8], "R7 held pixel", held, pat(5, 2)[15:8]);
      repeat (5) @(negedge clk); #1;
      chk(pix_out == held, "R7 pixel stable", pix_out, held);
      chk(ram_addr == {LINE_W'(5), COL_W'(SLOTS - 1)}, "R8 host col reg", ram_addr,
          {LINE_W'(5), COL_W'(SLOTS - 1)});
    end
    write_ctrl(4'b0000);
    chk(ram_addr[COL_W-1:0] == 3, "R7 resume col", ram_addr[COL_W-1:0], 3);
    @(negedge clk); #1;
    chk(ram_addr[COL_W-1:0] == 4, "R7 next col", ram_addr[COL_W-1:0], 4);

    // R9 sync
    write_ctrl(4'b0100);
    chk(hsync == 1, "R9 sync on", hsync, 1);
    write_ctrl(4'b0000);
    chk(hsync == 0, "R9 sync off", hsync, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule